// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block produces the current word address for a synchronous burst memory that moves through four-beat bursts. On a load cycle it captures a whole external address. The bits above the burst field are held in a register for the rest of the burst. The bits inside the burst field are then stepped through a four-address sequence, one step for each advance request. The sequence can start at any offset inside the four-word group.

Two orders are available. Linear order adds one modulo four on each step. Interleaved order gives the start offset XOR the number of steps taken since the load. An order-select input picks the order. It is sampled only while reset is held and is treated as static afterwards.

A load can come from either of two active-low strobes. The processor strobe counts only while the active-low primary enable is low. The controller strobe is always seen, but it loads only when the device is fully enabled. If it is seen while the device is not enabled, the cycle is a deselect and the address is held. When neither strobe acts, the active-low advance input chooses between stepping and suspending the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: With the controller strobe low, the primary enable low and the select qualifier high, the address output equals the external address from the clock edge after that cycle.
- R2: With the processor strobe low, the primary enable low and the select qualifier high, the address output equals the external address from the clock edge after that cycle.
- R3: When the primary enable is high, a low processor strobe has no effect. With the controller strobe high, the advance input alone then decides between a hold and a step.
- R4: A strobe that is seen while the device is not enabled (select low, or a controller strobe with the primary enable high) loads nothing and leaves the address output unchanged.
- R5: With linear order latched (order-select low at reset), the burst field reads start, start+1, start+2, start+3, all modulo 4.
- R6: With interleaved order latched (order-select high at reset), the burst field on step n of a burst (n = 0..3) reads start XOR n.
- R7: The advance after the fourth address of a burst returns the burst field to the value that was loaded.
- R8: With both strobes high and the advance input high, the address output holds. A burst suspended in the middle resumes from the held address.
- R9: A step never changes the address bits above the two-bit burst field.
- R10: A change of order-select after reset has been released does not change the order in use.
- R11: While reset is asserted and right after it is released, the address output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; order-select is sampled while it is low |
| addr_in | input | ADDR_W | External address for load cycles |
| strb_p_n | input | 1 | Processor load strobe, active low, qualified by en_n |
| strb_c_n | input | 1 | Controller load strobe, active low |
| adv_n | input | 1 | Advance request, active low; high suspends the burst |
| en_n | input | 1 | Primary enable, active low |
| sel | input | 1 | Select qualifier, active high |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_out | output | ADDR_W | Current address: held upper bits and sequenced burst field |

## Verification
The bench builds the block with an eight-bit address and a two-bit burst field. Six upper bits are enough to show when the upper part of the address changes. Every start offset of the burst field can be reached in a single load. With these widths each vector can give its expected address as one byte, so the first step, the suspend, the wrap and every order can be told apart from a single output value. Both orders are run from all four start offsets, with a suspend placed inside each burst, and order-select is flipped after reset to show that the order does not change.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_STEP = 2'd2
   } bsq_cmd_e;
endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
   import bsq_pkg::*;
(
   input  logic     strb_p_n,
   input  logic     strb_c_n,
   input  logic     adv_n,
   input  logic     en_n,
   input  logic     sel,
   output bsq_cmd_e cmd
);
   logic p_seen;
   logic c_seen;
   logic enabled;

   // the processor strobe is masked by the primary enable
   assign p_seen  = !strb_p_n && !en_n;
   assign c_seen  = !strb_c_n;
   assign enabled = !en_n && sel;

   always_comb begin
      if (p_seen || c_seen) begin
         cmd = enabled ? CMD_LOAD : CMD_HOLD;
      end else if (!adv_n) begin
         cmd = CMD_STEP;
      end else begin
         cmd = CMD_HOLD;
      end
   end
endmodule

// File: rtl/bsq_beat.sv
module bsq_beat
   import bsq_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bsq_cmd_e         cmd,
   input  logic [CNT_W-1:0] load_off,
   output logic [CNT_W-1:0] start_off,
   output logic [CNT_W-1:0] beat
);
   localparam logic [CNT_W-1:0] LAST_BEAT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_off <= '0;
         beat      <= '0;
      end else begin
         unique case (cmd)
            CMD_LOAD: begin
               start_off <= load_off;
               beat      <= '0;
            end
            CMD_STEP: beat <= beat + 1'b1;
            default:  beat <= beat;
         endcase
      end
   end

   // R7: the step after the last beat brings the count back to zero
   a_r7_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_STEP && beat == LAST_BEAT) |=> beat == '0);

   // R1: a load restarts the beat count
   a_r1_beat_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LOAD) |=> beat == '0);
endmodule

// File: rtl/bsq_order.sv
module bsq_order #(
   parameter int CNT_W = 2
) (
   input  logic             interleave,
   input  logic [CNT_W-1:0] start_off,
   input  logic [CNT_W-1:0] beat,
   output logic [CNT_W-1:0] low
);
   generate
      if (CNT_W == 1) begin : g_single
         // with one bit the two orders coincide
         assign low = start_off ^ beat;
      end else begin : g_multi
         logic [CNT_W-1:0] lin_val;
         logic [CNT_W-1:0] ilv_val;
         assign lin_val = start_off + beat;
         assign ilv_val = start_off ^ beat;
         assign low     = interleave ? ilv_val : lin_val;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              strb_p_n,
   input  logic              strb_c_n,
   input  logic              adv_n,
   input  logic              en_n,
   input  logic              sel,
   input  logic              order_sel,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int UP_W = ADDR_W - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W >= ADDR_W) begin : g_bad_width
         $error("burst_addr_seq: CNT_W must be at least 1 and below ADDR_W");
      end
   endgenerate

   bsq_cmd_e          cmd;
   logic [UP_W-1:0]   upper_q;
   logic [CNT_W-1:0]  start_off;
   logic [CNT_W-1:0]  beat;
   logic [CNT_W-1:0]  low;
   logic              order_q;

   bsq_ctrl u_ctrl (
      .strb_p_n (strb_p_n),
      .strb_c_n (strb_c_n),
      .adv_n    (adv_n),
      .en_n     (en_n),
      .sel      (sel),
      .cmd      (cmd)
   );

   bsq_beat #(.CNT_W(CNT_W)) u_beat (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .load_off  (addr_in[CNT_W-1:0]),
      .start_off (start_off),
      .beat      (beat)
   );

   bsq_order #(.CNT_W(CNT_W)) u_order (
      .interleave (order_q),
      .start_off  (start_off),
      .beat       (beat),
      .low        (low)
   );

   // order select is captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) order_q <= order_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               upper_q <= '0;
      else if (cmd == CMD_LOAD) upper_q <= addr_in[ADDR_W-1:CNT_W];
   end

   assign addr_out = {upper_q, low};

   a_r1_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_c_n && !en_n && sel) |=> addr_out == $past(addr_in));

   a_r2_proc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_p_n && !en_n && sel) |=> addr_out == $past(addr_in));

   a_r3_proc_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en_n && strb_c_n && adv_n) |=> $stable(addr_out));

   a_r4_deselect_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((!strb_c_n || (!strb_p_n && !en_n)) && (en_n || !sel)) |=> $stable(addr_out));

   a_r8_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_p_n && strb_c_n && adv_n) |=> $stable(addr_out));

   a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_c_n && (strb_p_n || en_n) && !adv_n)
      |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

   a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!order_q && strb_c_n && (strb_p_n || en_n) && !adv_n)
      |=> addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
   localparam int CLK_P  = 10;
   localparam int AW     = 8;
   localparam int CW     = 2;
   localparam int NVEC   = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1;
   logic          en_n = 1'b0, sel = 1'b1, order_sel = 1'b0;
   logic [AW-1:0] addr_out;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strb_p_n(strb_p_n),
      .strb_c_n(strb_c_n), .adv_n(adv_n), .en_n(en_n), .sel(sel),
      .order_sel(order_sel), .addr_out(addr_out)
   );

   // {p_n, c_n, adv_n, en_n, sel, addr[7:0], expected[7:0], requirement}
   localparam logic [24:0] VEC [NVEC] = '{
      {5'b10101, 8'hA5, 8'hA5, 4'd1},  // R1 controller load
      {5'b11001, 8'h00, 8'hA6, 4'd5},  // R5 linear step
      {5'b11101, 8'h00, 8'hA6, 4'd8},  // R8 suspend
      {5'b11001, 8'h00, 8'hA7, 4'd5},  // R5
      {5'b11001, 8'h00, 8'hA4, 4'd5},  // R5 modulo 4
      {5'b11001, 8'h00, 8'hA5, 4'd7},  // R7 back to start
      {5'b01111, 8'h33, 8'hA5, 4'd3},  // R3 masked strobe, hold
      {5'b01011, 8'h33, 8'hA6, 4'd3},  // R3 masked strobe, step
      {5'b10100, 8'h10, 8'hA6, 4'd4},  // R4 select low
      {5'b01101, 8'h4F, 8'h4F, 4'd2},  // R2 processor load
      {5'b11001, 8'h00, 8'h4C, 4'd9},  // R9 upper bits kept on wrap
      {5'b10111, 8'h20, 8'h4C, 4'd4},  // R4 controller strobe, enable high
      {5'b01100, 8'h77, 8'h4C, 4'd4}   // R4 processor strobe, select low
   };

   task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic drive(input logic p, input logic c, input logic a, input logic e,
                        input logic s, input logic [AW-1:0] ad);
      @(negedge clk);
      strb_p_n = p; strb_c_n = c; adv_n = a; en_n = e; sel = s; addr_in = ad;
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst_n = 1'b0; order_sel = mode;
      strb_p_n = 1'b1; strb_c_n = 1'b1; adv_n = 1'b1;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      check("R11", addr_out, '0);
      @(negedge clk);
      rst_n = 1'b1;
      order_sel = ~mode;  // R10: must be ignored from here on
      @(posedge clk);
      #(CLK_P/4);
      check("R11", addr_out, '0);
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset(1'b0);
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
         check($sformatf("R%0d vec%0d", VEC[i][3:0], i), addr_out, VEC[i][11:4]);
      end

      // R5 R6 R7 R8 R10: every start offset in both orders, suspend mid-burst
      for (int m = 0; m < 2; m++) begin
         do_reset(m[0]);
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            logic [CW-1:0] exp_low;
            base = {6'(8'h2C + s * 5), 2'b00};
            drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, base | AW'(s));
            check("R1", addr_out, base | AW'(s));
            for (int n = 1; n <= 4; n++) begin
               drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
               exp_low = (m == 1) ? CW'(s ^ (n % 4)) : CW'(s + n);
               check((n == 4) ? "R7" : ((m == 1) ? "R6 R10" : "R5 R10"),
                     addr_out, base | AW'(exp_low));
               if (n == 2) begin
                  drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF);
                  check("R8", addr_out, base | AW'(exp_low));
               end
            end
         end
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule